// File: doc/BRIEF.md
# Opcode Control Decoder

This block is the main control decoder of a single-cycle 32-bit load/store RISC core. It reads the six-bit operation field at the top of the instruction word and produces, in the same cycle and with no storage, the signals that steer the datapath. These are the write-register choice, the second ALU operand choice, the writeback source choice, the memory read and write strobes, the register-file write enable, the conditional-branch enable and the jump select.

It also produces a two-bit ALU class. The class does not name an ALU operation. It goes to a separate function-field decoder, which either applies the class directly or looks at the low instruction bits. Every output has a defined value for every opcode. There are no don't-care states. Any opcode outside the supported set leaves all architectural state untouched.

Top module: `opc_ctrl_dec`

## Requirements
- R1: Only instruction bits 31..26 affect the outputs. Changing bits 25..0 never changes any output.
- R2: Opcode 0x00 (register-register) gives: rd_from_rd=1, rf_wr_en=1, opb_is_imm=0, wb_from_mem=0, no memory strobe, no branch, no jump, alu_class=2'b10.
- R3: Opcode 0x23 (load word) gives: mem_rd_en=1, wb_from_mem=1, opb_is_imm=1, rf_wr_en=1, rd_from_rd=0 (destination is taken from bits 20..16), alu_class=2'b00, and all other outputs 0.
- R4: Opcode 0x2B (store word) gives: mem_wr_en=1, opb_is_imm=1, rf_wr_en=0, alu_class=2'b00, and all other outputs 0.
- R5: Opcode 0x04 (branch on equal) gives: br_en=1, rf_wr_en=0, opb_is_imm=0 (both compare operands come from registers), alu_class=2'b01, and all other outputs 0.
- R6: Opcode 0x02 (jump) gives: jmp_sel=1, rf_wr_en=0, mem_wr_en=0, alu_class=2'b00, and all other outputs 0.
- R7: Every other opcode drives all outputs to 0. This includes the write enable, both memory strobes, the branch enable and the jump select, with alu_class=2'b00.
- R8: The alu_class encoding is 2'b00 for add, 2'b01 for subtract and 2'b10 for "decode the function field". The value 2'b11 is never produced.
- R9: mem_rd_en and mem_wr_en are never 1 together. rf_wr_en is never 1 while mem_wr_en, br_en or jmp_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word. Bits 31..26 hold the opcode. |
| rd_from_rd | output | 1 | 1: the write register comes from bits 15..11. 0: it comes from bits 20..16. |
| br_en | output | 1 | Enables the equality compare for a conditional branch. |
| mem_rd_en | output | 1 | Data memory read strobe. |
| mem_wr_en | output | 1 | Data memory write strobe. |
| wb_from_mem | output | 1 | 1: memory data is written back. 0: the ALU result is written back. |
| opb_is_imm | output | 1 | 1: the second ALU operand is the sign-extended bits 15..0. 0: it is the register addressed by bits 20..16. |
| rf_wr_en | output | 1 | Register file write enable. |
| jmp_sel | output | 1 | Selects the jump target for the next PC. |
| alu_class | output | 2 | ALU class passed to the function-field decoder. |

## Verification
Every output is a pure function of the instruction word. Each result is therefore due zero cycles after its stimulus, within the same clock period. The bench changes the instruction just after a falling edge of its free-running clock. It samples all ten control bits as one vector a quarter period later, well before the next rising edge. No check depends on register timing or on the order of processes at an edge. Each opcode is applied with several patterns in the low 26 bits, and all 64 opcodes are swept.

// File: rtl/opc_ctrl_dec.sv
module opc_ctrl_dec #(
  parameter int INSTR_W = 32,
  parameter int OP_W    = 6
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               rd_from_rd,
  output logic               br_en,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic               wb_from_mem,
  output logic               opb_is_imm,
  output logic               rf_wr_en,
  output logic               jmp_sel,
  output logic [1:0]         alu_class
);

  localparam int OP_LSB = INSTR_W - OP_W;

  localparam logic [OP_W-1:0] OP_RR  = OP_W'(6'h00);
  localparam logic [OP_W-1:0] OP_JMP = OP_W'(6'h02);
  localparam logic [OP_W-1:0] OP_BEQ = OP_W'(6'h04);
  localparam logic [OP_W-1:0] OP_LW  = OP_W'(6'h23);
  localparam logic [OP_W-1:0] OP_SW  = OP_W'(6'h2B);

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  logic [OP_W-1:0] op;
  logic            op_known;
  logic [9:0]      ctl;

  assign op = instr[INSTR_W-1:OP_LSB];

  // Vector layout: rd_from_rd, br_en, mem_rd_en, mem_wr_en, wb_from_mem,
  // opb_is_imm, rf_wr_en, jmp_sel, alu_class[1:0]
  always_comb begin
    unique case (op)
      OP_RR:   ctl = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, CLS_FN};
      OP_LW:   ctl = {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, CLS_ADD};
      OP_SW:   ctl = {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, CLS_ADD};
      OP_BEQ:  ctl = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, CLS_SUB};
      OP_JMP:  ctl = {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, CLS_ADD};
      default: ctl = '0;
    endcase
  end

  assign {rd_from_rd, br_en, mem_rd_en, mem_wr_en, wb_from_mem,
          opb_is_imm, rf_wr_en, jmp_sel, alu_class} = ctl;

  assign op_known = (op == OP_RR) || (op == OP_LW) || (op == OP_SW) ||
                    (op == OP_BEQ) || (op == OP_JMP);

  always_comb begin
    assert_unknown_quiet_R7: assert (op_known ||
      (ctl == '0));
    assert_no_class3_R8: assert (alu_class != 2'b11);
    assert_strobe_excl_R9: assert (!(mem_rd_en && mem_wr_en));
    assert_no_wr_conflict_R9: assert (!(rf_wr_en && (mem_wr_en || br_en || jmp_sel)));
    assert_load_path_R3: assert (!mem_rd_en || (wb_from_mem && opb_is_imm && rf_wr_en));
    assert_store_path_R4: assert (!mem_wr_en || (opb_is_imm && !rf_wr_en && alu_class == CLS_ADD));
    assert_branch_sub_R5: assert (!br_en || (alu_class == CLS_SUB && !opb_is_imm));
    assert_rd_only_rr_R2: assert (!rd_from_rd || (alu_class == CLS_FN && rf_wr_en));
  end

endmodule

// File: tb/opc_ctrl_dec_bench.sv
module opc_ctrl_dec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        rd_from_rd, br_en, mem_rd_en, mem_wr_en, wb_from_mem;
  logic        opb_is_imm, rf_wr_en, jmp_sel;
  logic [1:0]  alu_class;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  localparam logic [9:0] V_RR  = 10'b1000001010;
  localparam logic [9:0] V_LW  = 10'b0010111000;
  localparam logic [9:0] V_SW  = 10'b0001010000;
  localparam logic [9:0] V_BEQ = 10'b0100000001;
  localparam logic [9:0] V_JMP = 10'b0000000100;

  always #10 clk = ~clk;

  opc_ctrl_dec u_opc_ctrl_dec (
    .instr(instr), .rd_from_rd(rd_from_rd), .br_en(br_en),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .wb_from_mem(wb_from_mem),
    .opb_is_imm(opb_is_imm), .rf_wr_en(rf_wr_en), .jmp_sel(jmp_sel),
    .alu_class(alu_class)
  );

  function automatic logic [9:0] outv();
    return {rd_from_rd, br_en, mem_rd_en, mem_wr_en, wb_from_mem,
            opb_is_imm, rf_wr_en, jmp_sel, alu_class};
  endfunction

  task automatic apply_check(input logic [31:0] w, input logic [9:0] exp, input string req);
    @(negedge clk);
    instr = w;
    #5;
    n_run++;
    if (outv() !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%h actual=%b expected=%b", req, w, outv(), exp);
    end
  endtask

  task automatic run_op(input logic [5:0] op, input logic [9:0] exp, input string req);
    apply_check({op, 26'h0000000}, exp, req);
    apply_check({op, 26'h3FFFFFF}, exp, req);
    apply_check({op, 26'h2AAAAAA}, exp, req);
    apply_check({op, 26'h1555555}, exp, req);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    apply_check(32'h0000_0000, V_RR, "R2 initial word");
  endtask

  task automatic t_rr();    run_op(6'h00, V_RR,  "R2"); endtask
  task automatic t_load();  run_op(6'h23, V_LW,  "R3"); endtask
  task automatic t_store(); run_op(6'h2B, V_SW,  "R4"); endtask
  task automatic t_beq();   run_op(6'h04, V_BEQ, "R5"); endtask
  task automatic t_jump();  run_op(6'h02, V_JMP, "R6"); endtask

  task automatic t_low_bits_R1();
    apply_check(32'h0128_5020, V_RR,  "R1 low field");
    apply_check(32'h8D09_FFFC, V_LW,  "R1 low field");
    apply_check(32'hAD09_0004, V_SW,  "R1 low field");
    apply_check(32'h1109_FFFF, V_BEQ, "R1 low field");
    apply_check(32'h0BFF_FFFF, V_JMP, "R1 low field");
  endtask

  task automatic t_sweep_R7_R8();
    for (int k = 0; k < 64; k++) begin
      logic [9:0] e;
      case (k[5:0])
        6'h00: e = V_RR;
        6'h23: e = V_LW;
        6'h2B: e = V_SW;
        6'h04: e = V_BEQ;
        6'h02: e = V_JMP;
        default: e = 10'b0;
      endcase
      apply_check({k[5:0], 26'h15A5A5A}, e, "R7/R8 sweep");
      n_run++;
      if (alu_class == 2'b11 || (mem_rd_en && mem_wr_en) ||
          (rf_wr_en && (mem_wr_en || br_en || jmp_sel))) begin
        n_fail++;
        $display("FAIL R9 op=%h actual=%b expected=no conflict", k[5:0], outv());
      end
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset_state();
    t_rr();
    t_load();
    t_store();
    t_beq();
    t_jump();
    t_low_bits_R1();
    t_sweep_R7_R8();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule